// File: doc/BRIEF.md
# Stack Window Address Guard

This block watches the data-access path of a 32-bit soft processor and keeps accesses made through the stack pointer inside a window that software sets. The window is bounded by a lower and an upper limit register. Software writes and reads both limits with the special-register move instructions. Each memory instruction presents its decoded base and index register numbers, its format (register+register or register+immediate) and its operand values. The block forms the effective address from these.

An access is checked only if general register 1, the stack pointer, is its base operand. In the register+register format it is also checked if register 1 is the index operand. A checked access that falls outside the window raises a one-cycle exception request in the same cycle. On the following clock edge the exception address register takes the offending address and the exception status register takes cause code 7, a code shared with the privileged-instruction cause. After reset the upper limit is all ones and the lower limit is zero, so the guard cannot fire until software narrows the window.

Top module: `stack_guard`

## Requirements
- R1: After reset the lower limit reads 0x00000000, the upper limit reads 0xFFFFFFFF, the exception address and status outputs are 0, and no exception request is raised.
- R2: The effective address output is ra+rb when `fmt_rr_i`=1 and ra+imm when `fmt_rr_i`=0. It is computed modulo 2^32.
- R3: A checked access violates the window when its address is unsigned-less than the lower limit or unsigned-greater than the upper limit. An address equal to either limit is inside the window.
- R4: An access is checked when `ra_idx_i`=1. It is also checked when `fmt_rr_i`=1 and `rb_idx_i`=1. In the immediate format `rb_idx_i` has no effect.
- R5: `exc_req_o` is high only in a cycle where `ls_valid_i`=1 and the access is a checked violation. It rises combinationally in that same cycle.
- R6: At the clock edge that ends a violating cycle, `ear_o` takes that cycle's effective address.
- R7: At that same edge, `esr_o` takes cause code 7.
- R8: A move-to with `spr_addr_i`=0x800 writes the lower limit, and one with 0x802 writes the upper limit. The new value governs checks from the next cycle on. `spr_rdata_o` returns the full 32-bit limit at those numbers and 0 at any other number.
- R9: Cycles without an exception request leave `ear_o` and `esr_o` unchanged. This includes out-of-window accesses that do not use register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ls_valid_i | input | 1 | A load/store is presented this cycle |
| fmt_rr_i | input | 1 | 1 = register+register format, 0 = register+immediate |
| ra_idx_i | input | 5 | Base register number |
| rb_idx_i | input | 5 | Index register number |
| ra_val_i | input | 32 | Base register value |
| rb_val_i | input | 32 | Index register value |
| imm_i | input | 32 | Extended immediate, including any prefix |
| spr_wr_i | input | 1 | Move-to special register strobe |
| spr_addr_i | input | 14 | Special register number |
| spr_wdata_i | input | 32 | Move-to data |
| spr_rdata_o | output | 32 | Move-from data |
| eff_addr_o | output | 32 | Computed effective address |
| exc_req_o | output | 1 | Hardware-exception request pulse |
| ear_o | output | 32 | Exception address register |
| esr_o | output | 5 | Exception status cause code |

## Verification
The assertions check on every cycle that a request appears only for a valid access that uses register 1 and lies outside the current limits. They also check that every such access raises a request, that each request loads the address and the cause 7 on the next edge, that quiet cycles leave both registers stable, and that a limit write is seen the next cycle. The bench scenarios cover what the properties cannot: the arithmetic of both address formats against independent sums, including wrap-around and addresses exactly on a limit. They also cover the reset values read back through the move-from port, and a limit write made in the same cycle as an access, which must still be judged against the old limit.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
  localparam int unsigned NUM_BOUNDS = 2;
  typedef enum logic [0:0] {
    BND_LOW  = 1'b0,
    BND_HIGH = 1'b1
  } bound_sel_e;
endpackage

// File: rtl/sg_addr_gen.sv
module sg_addr_gen #(
  parameter int unsigned AW     = 32,
  parameter int unsigned IW     = 5,
  parameter int unsigned SP_IDX = 1
) (
  input  logic          fmt_rr_i,
  input  logic [IW-1:0] ra_idx_i,
  input  logic [IW-1:0] rb_idx_i,
  input  logic [AW-1:0] ra_val_i,
  input  logic [AW-1:0] rb_val_i,
  input  logic [AW-1:0] imm_i,
  output logic [AW-1:0] addr_o,
  output logic          uses_sp_o
);
  localparam logic [IW-1:0] SP = IW'(SP_IDX);

  logic [AW-1:0] op_b;

  assign op_b      = fmt_rr_i ? rb_val_i : imm_i;
  assign addr_o    = ra_val_i + op_b;
  // index operand only counts in the register+register format
  assign uses_sp_o = (ra_idx_i == SP) || (fmt_rr_i && (rb_idx_i == SP));
endmodule

// File: rtl/sg_bound_regs.sv
module sg_bound_regs
  import stack_guard_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned SW        = 14,
  parameter logic [SW-1:0] LOW_NUM  = 14'h800,
  parameter logic [SW-1:0] HIGH_NUM = 14'h802
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [SW-1:0] num_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output logic [AW-1:0] low_o,
  output logic [AW-1:0] high_o
);
  logic [AW-1:0] bnd_q   [NUM_BOUNDS];
  logic [NUM_BOUNDS-1:0] hit;

  for (genvar i = 0; i < NUM_BOUNDS; i++) begin : g_bnd
    localparam logic [SW-1:0] MY_NUM = (i == int'(BND_LOW)) ? LOW_NUM : HIGH_NUM;
    localparam logic [AW-1:0] RST_V  = (i == int'(BND_LOW)) ? '0 : '1;

    assign hit[i] = (num_i == MY_NUM);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             bnd_q[i] <= RST_V;
      else if (wr_i && hit[i]) bnd_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BOUNDS; i++) begin
      if (hit[i]) rdata_o = bnd_q[i];
    end
  end

  assign low_o  = bnd_q[BND_LOW];
  assign high_o = bnd_q[BND_HIGH];
endmodule

// File: rtl/sg_window_cmp.sv
module sg_window_cmp #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] low_i,
  input  logic [AW-1:0] high_i,
  output logic          outside_o
);
  logic below, above;

  // unsigned compares; limits are inclusive
  assign below     = addr_i < low_i;
  assign above     = addr_i > high_i;
  assign outside_o = below | above;
endmodule

// File: rtl/stack_guard.sv
module stack_guard #(
  parameter int unsigned AW         = 32,
  parameter int unsigned IW         = 5,
  parameter int unsigned SW         = 14,
  parameter int unsigned CW         = 5,
  parameter int unsigned SP_IDX     = 1,
  parameter int unsigned CAUSE_CODE = 7,
  parameter logic [SW-1:0] LOW_NUM  = 14'h800,
  parameter logic [SW-1:0] HIGH_NUM = 14'h802
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ls_valid_i,
  input  logic          fmt_rr_i,
  input  logic [IW-1:0] ra_idx_i,
  input  logic [IW-1:0] rb_idx_i,
  input  logic [AW-1:0] ra_val_i,
  input  logic [AW-1:0] rb_val_i,
  input  logic [AW-1:0] imm_i,
  input  logic          spr_wr_i,
  input  logic [SW-1:0] spr_addr_i,
  input  logic [AW-1:0] spr_wdata_i,
  output logic [AW-1:0] spr_rdata_o,
  output logic [AW-1:0] eff_addr_o,
  output logic          exc_req_o,
  output logic [AW-1:0] ear_o,
  output logic [CW-1:0] esr_o
);
  localparam logic [CW-1:0] CAUSE = CW'(CAUSE_CODE);

  logic          uses_sp;
  logic          outside;
  logic [AW-1:0] bnd_low, bnd_high;
  logic [AW-1:0] ear_q;
  logic [CW-1:0] esr_q;

  sg_addr_gen #(.AW(AW), .IW(IW), .SP_IDX(SP_IDX)) u_agen (
    .fmt_rr_i (fmt_rr_i),
    .ra_idx_i (ra_idx_i),
    .rb_idx_i (rb_idx_i),
    .ra_val_i (ra_val_i),
    .rb_val_i (rb_val_i),
    .imm_i    (imm_i),
    .addr_o   (eff_addr_o),
    .uses_sp_o(uses_sp)
  );

  sg_bound_regs #(.AW(AW), .SW(SW), .LOW_NUM(LOW_NUM), .HIGH_NUM(HIGH_NUM)) u_bnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (spr_wr_i),
    .num_i  (spr_addr_i),
    .wdata_i(spr_wdata_i),
    .rdata_o(spr_rdata_o),
    .low_o  (bnd_low),
    .high_o (bnd_high)
  );

  sg_window_cmp #(.AW(AW)) u_cmp (
    .addr_i   (eff_addr_o),
    .low_i    (bnd_low),
    .high_i   (bnd_high),
    .outside_o(outside)
  );

  assign exc_req_o = ls_valid_i & uses_sp & outside;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ear_q <= '0;
      esr_q <= '0;
    end else if (exc_req_o) begin
      ear_q <= eff_addr_o;
      esr_q <= CAUSE;
    end
  end

  assign ear_o = ear_q;
  assign esr_o = esr_q;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 5,
  parameter int unsigned SW = 14,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ls_valid_i,
  input logic          fmt_rr_i,
  input logic [IW-1:0] ra_idx_i,
  input logic [IW-1:0] rb_idx_i,
  input logic [AW-1:0] eff_addr_i,
  input logic          exc_req_i,
  input logic [AW-1:0] ear_i,
  input logic [CW-1:0] esr_i,
  input logic          spr_wr_i,
  input logic [SW-1:0] spr_addr_i,
  input logic [AW-1:0] spr_wdata_i,
  input logic [AW-1:0] low_i,
  input logic [AW-1:0] high_i
);
  logic guarded, out_win;
  assign guarded = (ra_idx_i == IW'(1)) || (fmt_rr_i && rb_idx_i == IW'(1));
  assign out_win = (eff_addr_i < low_i) || (eff_addr_i > high_i);

  p_req_needs_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |-> ls_valid_i);
  p_req_needs_sp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |-> guarded);
  p_req_outside_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |-> out_win);
  p_violation_fires_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_valid_i && guarded && out_win) |-> exc_req_i);
  p_ear_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> ear_i == $past(eff_addr_i));
  p_esr_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> esr_i == CW'(7));
  p_quiet_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_i |=> ($stable(ear_i) && $stable(esr_i)));
  p_low_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_wr_i && spr_addr_i == SW'(14'h800)) |=> low_i == $past(spr_wdata_i));
  p_high_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_wr_i && spr_addr_i == SW'(14'h802)) |=> high_i == $past(spr_wdata_i));
endmodule

bind stack_guard sg_checker #(.AW(AW), .IW(IW), .SW(SW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ls_valid_i (ls_valid_i),
  .fmt_rr_i   (fmt_rr_i),
  .ra_idx_i   (ra_idx_i),
  .rb_idx_i   (rb_idx_i),
  .eff_addr_i (eff_addr_o),
  .exc_req_i  (exc_req_o),
  .ear_i      (ear_o),
  .esr_i      (esr_o),
  .spr_wr_i   (spr_wr_i),
  .spr_addr_i (spr_addr_i),
  .spr_wdata_i(spr_wdata_i),
  .low_i      (bnd_low),
  .high_i     (bnd_high)
);

// File: tb/sim_stack_guard.sv
module sim_stack_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ls_valid_i = 1'b0, fmt_rr_i = 1'b0;
  logic [4:0]  ra_idx_i = '0, rb_idx_i = '0;
  logic [31:0] ra_val_i = '0, rb_val_i = '0, imm_i = '0;
  logic        spr_wr_i = 1'b0;
  logic [13:0] spr_addr_i = '0;
  logic [31:0] spr_wdata_i = '0;
  logic [31:0] spr_rdata_o, eff_addr_o, ear_o;
  logic        exc_req_o;
  logic [4:0]  esr_o;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_ear;
  logic [4:0]  exp_esr;

  always #10 clk_i = ~clk_i;

  stack_guard u0 (.*);

  typedef struct packed {
    logic [4:0]  ra_idx;
    logic [4:0]  rb_idx;
    logic        rr;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp_addr;
    logic        exp_exc;
  } vec_t;

  // window is 0x1000..0x1FFF while the table runs
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{5'd1, 5'd0, 1'b0, 32'h0000_1000, 32'h0000_0000, 32'h0000_1000, 1'b0},
    '{5'd1, 5'd0, 1'b0, 32'h0000_1000, 32'h0000_0FFF, 32'h0000_1FFF, 1'b0},
    '{5'd1, 5'd0, 1'b0, 32'h0000_1FFF, 32'h0000_0001, 32'h0000_2000, 1'b1},
    '{5'd1, 5'd0, 1'b0, 32'h0000_1000, 32'hFFFF_FFFF, 32'h0000_0FFF, 1'b1},
    '{5'd3, 5'd1, 1'b1, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 1'b1},
    '{5'd3, 5'd1, 1'b0, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 1'b0},
    '{5'd5, 5'd6, 1'b1, 32'h0000_4000, 32'h0000_1000, 32'h0000_5000, 1'b0},
    '{5'd1, 5'd2, 1'b1, 32'h0000_1800, 32'h0000_0100, 32'h0000_1900, 1'b0},
    '{5'd1, 5'd0, 1'b0, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic spr_write(input logic [13:0] n, input logic [31:0] d);
    @(negedge clk_i);
    spr_wr_i = 1'b1; spr_addr_i = n; spr_wdata_i = d;
    @(negedge clk_i);
    spr_wr_i = 1'b0;
  endtask

  task automatic spr_read(input logic [13:0] n, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    spr_addr_i = n;
    #2 check(req, spr_rdata_o, exp);
  endtask

  task automatic access(input logic [4:0] ra, input logic [4:0] rb, input logic rr,
                        input logic [31:0] a, input logic [31:0] b, input logic v);
    @(negedge clk_i);
    ls_valid_i = v; ra_idx_i = ra; rb_idx_i = rb; fmt_rr_i = rr; ra_val_i = a;
    rb_val_i = rr ? b : 32'hDEAD_0000;
    imm_i    = rr ? 32'h0BAD_0000 : b;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #35 rst_ni = 1'b1;
    // R1 reset state
    spr_read(14'h800, 32'h0, "R1 low reset");
    spr_read(14'h802, 32'hFFFF_FFFF, "R1 high reset");
    check("R1 ear reset", ear_o, 32'h0);
    check("R1 esr reset", 32'(esr_o), 32'h0);
    access(5'd1, 5'd0, 1'b0, 32'hFFFF_FFF0, 32'h0F, 1'b1);
    #2 check("R1 no request with open window", 32'(exc_req_o), 32'h0);
    access(5'd0, 5'd0, 1'b0, 32'h0, 32'h0, 1'b0);

    // R8 program window, read back, unmapped number
    spr_write(14'h800, 32'h0000_1000);
    spr_write(14'h802, 32'h0000_1FFF);
    spr_read(14'h800, 32'h0000_1000, "R8 low readback");
    spr_read(14'h802, 32'h0000_1FFF, "R8 high readback");
    spr_read(14'h801, 32'h0, "R8 unmapped reads zero");

    exp_ear = 32'h0; exp_esr = 5'd0;
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].ra_idx, VEC[i].rb_idx, VEC[i].rr, VEC[i].a, VEC[i].b, 1'b1);
      #2;
      check($sformatf("R2 addr vec%0d", i), eff_addr_o, VEC[i].exp_addr);
      check($sformatf("R3/R4 req vec%0d", i), 32'(exc_req_o), 32'(VEC[i].exp_exc));
      if (VEC[i].exp_exc) begin exp_ear = VEC[i].exp_addr; exp_esr = 5'd7; end
      @(negedge clk_i);
      check($sformatf("R6/R9 ear vec%0d", i), ear_o, exp_ear);
      check($sformatf("R7/R9 esr vec%0d", i), 32'(esr_o), 32'(exp_esr));
    end

    // R5 guarded violation without valid strobe
    access(5'd1, 5'd0, 1'b0, 32'h0000_0100, 32'h0, 1'b0);
    #2 check("R5 idle no request", 32'(exc_req_o), 32'h0);
    @(negedge clk_i);
    check("R5 idle ear held", ear_o, exp_ear);
    ls_valid_i = 1'b1;
    #2 check("R5 valid raises request", 32'(exc_req_o), 32'h1);
    @(negedge clk_i);
    check("R6 ear 0x100", ear_o, 32'h0000_0100);
    ls_valid_i = 1'b0;

    // R8 write timing: same-cycle access sees old limit
    spr_write(14'h802, 32'hFFFF_FFFF);
    access(5'd1, 5'd0, 1'b0, 32'h0000_2000, 32'h0, 1'b1);
    spr_wr_i = 1'b1; spr_addr_i = 14'h800; spr_wdata_i = 32'h0000_3000;
    #2 check("R8 old low still used", 32'(exc_req_o), 32'h0);
    @(negedge clk_i);
    spr_wr_i = 1'b0;
    #2 check("R8 new low in effect", 32'(exc_req_o), 32'h1);
    @(negedge clk_i);
    ls_valid_i = 1'b0;
    check("R6 ear after new low", ear_o, 32'h0000_2000);
    spr_read(14'h800, 32'h0000_3000, "R8 low full value");

    // R1 second reset restores open window
    rst_ni = 1'b0;
    #3 check("R1 ear cleared", ear_o, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    spr_read(14'h800, 32'h0, "R1 low after reset");
    spr_read(14'h802, 32'hFFFF_FFFF, "R1 high after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule